// File: doc/BRIEF.md
# DMA Channel Destination Address and Acknowledge Unit

This unit is the per-channel piece of a DMA controller that owns the destination side of a transfer. It keeps the destination address and a small control word. The control word holds a two-bit destination stepping mode, an acknowledge-timing bit and an acknowledge-polarity bit. The unit also samples a transfer-unit size code and an addressing-mode flag that come from elsewhere in the channel. A bus sequencer pulses a read-cycle strobe and a write-cycle strobe for every transfer unit. The unit moves the address when a unit completes and drives the external acknowledge pin during the proper bus cycle.

Software reaches the unit through a one-port register write interface. `reg_sel` = 0 writes the control word and `reg_sel` = 1 loads the destination address. The current control word is always visible on `ctrl_rdata`. Combinations of mode and size that cannot be honoured raise `cfg_err` and freeze the address. The error clears once the fields describe a legal combination again. The acknowledge fields exist only when the `CHAN_IDX` parameter is below `ACK_CHANS`. On any other channel the pin rests at its inactive (high) level. All pins are plain control and status signals with no valid/ready handshake. The strobes are one-cycle pulses that the unit never stalls, so the unit applies no back-pressure.

Top module: `dma_dest_ack_unit`

## Requirements
- R1: While and after reset, the destination address is 0, `ctrl_rdata` is 0, `cfg_err` is 0 and `ack_pin` is 1 (inactive, since low-active polarity is the reset choice).
- R2: With destination mode 01 (step up), each clock edge on which `wr_cyc` is high and no address load occurs adds the unit size to the address. The size code is `xfer_size` 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes. The sum wraps modulo 2^32.
- R3: With destination mode 10 (step down) and size codes 0, 1 or 2, each completing edge subtracts 1, 2 or 4, modulo 2^32.
- R4: With destination mode 00 (hold), the address does not change on completing edges.
- R5: `cfg_err` is high whenever the control word and size code form an illegal combination and the mode bits are not ignored (see R7). The illegal combinations are mode 11 with any size, and size code 3 with mode 00 or 10. While `cfg_err` is high the address does not step. Rewriting a legal combination clears the flag.
- R6: In dual address mode (`dual_addr` = 1), the acknowledge is active during `rd_cyc` when control bit 4 is 0 and during `wr_cyc` when bit 4 is 1. It is inactive otherwise.
- R7: In single address mode (`dual_addr` = 0), the acknowledge is active during either strobe, whatever bit 4 holds. When `single_to_dev` = 1, the destination mode bits are ignored: the address never steps and `cfg_err` stays low.
- R8: Control bit 5 selects polarity. With 0 the pin is low while active and high otherwise. With 1 the pin is high while active and low otherwise.
- R9: When `CHAN_IDX` >= `ACK_CHANS`, writes to control bits 4 and 5 are dropped, those bits read back as 0, and `ack_pin` stays 1 at all times.
- R10: Control bits other than 1:0, 4 and 5 are reserved and always read back as 0. The mode occupies bits 1:0.
- R11: An address write (`reg_we` = 1, `reg_sel` = 1) sets the address to `reg_wdata` on that edge. It takes priority over a step on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 control word, 1 destination address |
| reg_wdata | input | ADDR_W | Write data |
| xfer_size | input | 2 | Transfer unit size code |
| dual_addr | input | 1 | 1 dual address mode, 0 single address mode |
| single_to_dev | input | 1 | Single mode: destination is the acknowledged device |
| rd_cyc | input | 1 | Read cycle strobe of the current unit |
| wr_cyc | input | 1 | Write cycle strobe; its edge completes the unit |
| ctrl_rdata | output | ADDR_W | Control word readback |
| dest_addr | output | ADDR_W | Current destination address |
| ack_pin | output | 1 | External acknowledge with programmed polarity |
| cfg_err | output | 1 | Illegal mode/size combination flag |

## Verification
The bench goes after the step table. A design that used a shift for the burst size would move by 8 instead of 16. One that sign-extended badly would corrupt the address when it wraps past zero. The illegal combinations are exercised to catch a unit that keeps stepping or never clears its flag. Those are the burst size with hold or step-down, and the reserved mode. Acknowledge timing is checked in both addressing modes and both polarities. A unit that honoured the timing bit in single mode would miss half its strobes, and a swapped polarity would invert the idle level. A second instance on a high channel shows that the acknowledge fields are dropped there. A same-edge load and step shows which one wins.

// File: rtl/dmachan_pkg.sv
package dmachan_pkg;

  typedef enum logic [1:0] {
    DST_HOLD = 2'b00,
    DST_UP   = 2'b01,
    DST_DOWN = 2'b10,
    DST_BAD  = 2'b11
  } dst_mode_e;

  typedef enum logic [1:0] {
    UNIT_B1  = 2'd0,
    UNIT_B2  = 2'd1,
    UNIT_B4  = 2'd2,
    UNIT_B16 = 2'd3
  } unit_e;

  localparam int MODE_LSB = 0;
  localparam int AWR_BIT  = 4;
  localparam int AHI_BIT  = 5;

  typedef struct packed {
    logic      ack_hi;
    logic      ack_on_wr;
    dst_mode_e mode;
  } chan_cfg_t;

endpackage

// File: rtl/chan_cfg_reg.sv
module chan_cfg_reg
  import dmachan_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit ACK_IMPL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output chan_cfg_t         cfg,
  output logic [DATA_W-1:0] cfg_rdata
);

  dst_mode_e mode_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      mode_q <= DST_HOLD;
    else if (cfg_we) mode_q <= dst_mode_e'(cfg_wdata[MODE_LSB +: 2]);
  end

  logic awr_q, ahi_q;

  generate
    if (ACK_IMPL) begin : g_ack_fields
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          awr_q <= 1'b0;
          ahi_q <= 1'b0;
        end else if (cfg_we) begin
          awr_q <= cfg_wdata[AWR_BIT];
          ahi_q <= cfg_wdata[AHI_BIT];
        end
      end
    end else begin : g_no_ack_fields
      assign awr_q = 1'b0;
      assign ahi_q = 1'b0;
    end
  endgenerate

  always_comb begin
    cfg.mode      = mode_q;
    cfg.ack_on_wr = awr_q;
    cfg.ack_hi    = ahi_q;
  end

  always_comb begin
    cfg_rdata                  = '0;
    cfg_rdata[MODE_LSB +: 2]   = mode_q;
    cfg_rdata[AWR_BIT]         = awr_q;
    cfg_rdata[AHI_BIT]         = ahi_q;
  end

  // R1: the field is cleared by reset
  assert property (@(posedge clk) !rst_n |=> mode_q == DST_HOLD)
    else $error("assert_cfg_reset_R1");

endmodule

// File: rtl/dest_step_calc.sv
module dest_step_calc
  import dmachan_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  dst_mode_e         mode,
  input  unit_e             unit,
  input  logic              dual,
  input  logic              to_dev,
  output logic [ADDR_W-1:0] step,
  output logic              down,
  output logic              move,
  output logic              illegal
);

  logic ignored, bad;

  always_comb begin
    unique case (unit)
      UNIT_B1:  step = ADDR_W'(1);
      UNIT_B2:  step = ADDR_W'(2);
      UNIT_B4:  step = ADDR_W'(4);
      default:  step = ADDR_W'(16);
    endcase
  end

  always_comb begin
    ignored = !dual && to_dev;
    bad     = (mode == DST_BAD) || ((unit == UNIT_B16) && (mode != DST_UP));
    illegal = bad && !ignored;
    move    = !ignored && !bad && (mode != DST_HOLD);
    down    = (mode == DST_DOWN);
  end

  // R5: a burst step is only ever an upward one
  always_comb begin
    if (move && unit == UNIT_B16)
      assert_burst_up_only_R5: assert (!down);
  end

endmodule

// File: rtl/dest_addr_reg.sv
module dest_addr_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_val,
  input  logic              adv,
  input  logic              down,
  input  logic [ADDR_W-1:0] step,
  output logic [ADDR_W-1:0] addr
);

  always_ff @(posedge clk) begin
    if (!rst_n)      addr <= '0;
    else if (load)   addr <= load_val;
    else if (adv)    addr <= down ? addr - step : addr + step;
  end

  assert_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> addr == $past(load_val));

endmodule

// File: rtl/ack_gen.sv
module ack_gen #(
  parameter bit ACK_IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_cyc,
  input  logic wr_cyc,
  input  logic dual,
  input  logic ack_on_wr,
  input  logic ack_hi,
  output logic ack_pin
);

  generate
    if (ACK_IMPL) begin : g_ack
      logic active;
      always_comb begin
        if (dual) active = ack_on_wr ? wr_cyc : rd_cyc;
        else      active = rd_cyc || wr_cyc;
        ack_pin = ack_hi ? active : !active;
      end

      // R8: with no strobe the pin rests at the inactive level
      always_comb begin
        if (rst_n && !rd_cyc && !wr_cyc)
          assert_ack_idle_R8: assert (ack_pin == !ack_hi);
      end
    end else begin : g_no_ack
      assign ack_pin = 1'b1;
    end
  endgenerate

  // R6: in dual mode with write timing, a read-only cycle never asserts
  assert_dual_wr_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (dual && ack_on_wr && rd_cyc && !wr_cyc) |-> (ack_pin == !ack_hi));

endmodule

// File: rtl/dma_dest_ack_unit.sv
module dma_dest_ack_unit
  import dmachan_pkg::*;
#(
  parameter int CHAN_IDX  = 0,
  parameter int ACK_CHANS = 2,
  parameter int ADDR_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [ADDR_W-1:0] reg_wdata,
  input  logic [1:0]        xfer_size,
  input  logic              dual_addr,
  input  logic              single_to_dev,
  input  logic              rd_cyc,
  input  logic              wr_cyc,
  output logic [ADDR_W-1:0] ctrl_rdata,
  output logic [ADDR_W-1:0] dest_addr,
  output logic              ack_pin,
  output logic              cfg_err
);

  localparam bit ACK_IMPL = (CHAN_IDX < ACK_CHANS);
  localparam logic [ADDR_W-1:0] RD_MASK =
    ADDR_W'(32'h3) | (ADDR_W'(1) << AWR_BIT) | (ADDR_W'(1) << AHI_BIT);

  chan_cfg_t         cfg;
  logic [ADDR_W-1:0] step;
  logic              down, move, illegal;
  logic              cfg_load, addr_load, adv;

  assign cfg_load  = reg_we && !reg_sel;
  assign addr_load = reg_we && reg_sel;
  assign adv       = wr_cyc && move;
  assign cfg_err   = illegal;

  chan_cfg_reg #(.DATA_W(ADDR_W), .ACK_IMPL(ACK_IMPL)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_load), .cfg_wdata(reg_wdata),
    .cfg(cfg), .cfg_rdata(ctrl_rdata)
  );

  dest_step_calc #(.ADDR_W(ADDR_W)) u_step (
    .mode(cfg.mode), .unit(unit_e'(xfer_size)), .dual(dual_addr),
    .to_dev(single_to_dev), .step(step), .down(down), .move(move),
    .illegal(illegal)
  );

  dest_addr_reg #(.ADDR_W(ADDR_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_val(reg_wdata),
    .adv(adv), .down(down), .step(step), .addr(dest_addr)
  );

  ack_gen #(.ACK_IMPL(ACK_IMPL)) u_ack (
    .clk(clk), .rst_n(rst_n), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc),
    .dual(dual_addr), .ack_on_wr(cfg.ack_on_wr), .ack_hi(cfg.ack_hi),
    .ack_pin(ack_pin)
  );

  assert_frozen_on_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_err && !addr_load) |=> $stable(dest_addr));

  assert_hold_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.mode == DST_HOLD && wr_cyc && !addr_load) |=> $stable(dest_addr));

  assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !down && !addr_load) |=> dest_addr == $past(dest_addr) + $past(step));

  always_comb begin
    if (rst_n)
      assert_rsvd_zero_R10: assert ((ctrl_rdata & ~RD_MASK) == '0);
  end

  generate
    if (!ACK_IMPL) begin : g_tie_chk
      always_comb begin
        if (rst_n) assert_ack_tied_R9: assert (ack_pin == 1'b1);
      end
    end
  endgenerate

endmodule

// File: tb/dma_dest_ack_unit_test.sv
module dma_dest_ack_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam int HI_CHAN    = 2;

  logic        clk = 1'b0;
  logic        rst_n, reg_we, reg_sel, dual_addr, single_to_dev, rd_cyc, wr_cyc;
  logic [31:0] reg_wdata;
  logic [1:0]  xfer_size;

  logic [31:0] rdata0, rdata2, addr0, addr2;
  logic        ack0, ack2, err0, err2;

  int    compared = 0;
  int    mismatched = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_dest_ack_unit #(.CHAN_IDX(0)) uut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .xfer_size(xfer_size), .dual_addr(dual_addr),
    .single_to_dev(single_to_dev), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc),
    .ctrl_rdata(rdata0), .dest_addr(addr0), .ack_pin(ack0), .cfg_err(err0));

  dma_dest_ack_unit #(.CHAN_IDX(HI_CHAN)) uut_hi (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .xfer_size(xfer_size), .dual_addr(dual_addr),
    .single_to_dev(single_to_dev), .rd_cyc(rd_cyc), .wr_cyc(wr_cyc),
    .ctrl_rdata(rdata2), .dest_addr(addr2), .ack_pin(ack2), .cfg_err(err2));

  // Behavioural reference: index 0 has acknowledge fields, index 1 does not
  logic [1:0]  m_mode [2];
  logic        m_aw [2];
  logic        m_ah [2];
  logic [31:0] m_addr [2];

  function automatic bit exp_bad(input int ch);
    return (m_mode[ch] == 2'b11) || (xfer_size == 2'd3 && m_mode[ch] != 2'b01);
  endfunction

  function automatic bit exp_ignored();
    return !dual_addr && single_to_dev;
  endfunction

  function automatic logic [31:0] exp_step();
    case (xfer_size)
      2'd0: return 32'd1;
      2'd1: return 32'd2;
      2'd2: return 32'd4;
      default: return 32'd16;
    endcase
  endfunction

  always @(posedge clk) begin
    for (int ch = 0; ch < 2; ch++) begin
      if (!rst_n) begin
        m_mode[ch] = 2'b00; m_aw[ch] = 1'b0; m_ah[ch] = 1'b0; m_addr[ch] = 32'd0;
      end else begin
        logic bad, ign;
        bad = exp_bad(ch);
        ign = exp_ignored();
        if (reg_we && reg_sel) m_addr[ch] = reg_wdata;
        else if (wr_cyc && !bad && !ign && m_mode[ch] == 2'b01) m_addr[ch] = m_addr[ch] + exp_step();
        else if (wr_cyc && !bad && !ign && m_mode[ch] == 2'b10) m_addr[ch] = m_addr[ch] - exp_step();
        if (reg_we && !reg_sel) begin
          m_mode[ch] = reg_wdata[1:0];
          if (ch == 0) begin
            m_aw[ch] = reg_wdata[4];
            m_ah[ch] = reg_wdata[5];
          end
        end
      end
    end
  end

  task automatic check(input int ch, input string what, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s chan%0d %s actual=%h expected=%h", cur_req, ch, what, act, exp);
    end
  endtask

  task automatic compare_all();
    for (int ch = 0; ch < 2; ch++) begin
      logic        active, pin, err;
      logic [31:0] rd;
      active = (ch == 0) && (dual_addr ? (m_aw[ch] ? wr_cyc : rd_cyc) : (rd_cyc || wr_cyc));
      pin    = m_ah[ch] ? active : !active;
      err    = rst_n && exp_bad(ch) && !exp_ignored();
      rd     = {26'd0, m_ah[ch], m_aw[ch], 2'b00, m_mode[ch]};
      check(ch, "dest_addr",  ch == 0 ? addr0  : addr2,  m_addr[ch]);
      check(ch, "ctrl_rdata", ch == 0 ? rdata0 : rdata2, rd);
      check(ch, "ack_pin",    {31'd0, ch == 0 ? ack0 : ack2}, {31'd0, pin});
      check(ch, "cfg_err",    {31'd0, ch == 0 ? err0 : err2}, {31'd0, err});
    end
  endtask

  task automatic drive(input bit we, input bit sel, input logic [31:0] wd, input bit rd, input bit wr);
    reg_we = we; reg_sel = sel; reg_wdata = wd; rd_cyc = rd; wr_cyc = wr;
    @(posedge clk);
    @(negedge clk);
    compare_all();
    reg_we = 1'b0; rd_cyc = 1'b0; wr_cyc = 1'b0;
  endtask

  task automatic wr_ctrl(input logic [31:0] v); drive(1, 0, v, 0, 0); endtask
  task automatic wr_addr(input logic [31:0] v); drive(1, 1, v, 0, 0); endtask
  task automatic one_unit(); drive(0, 0, 0, 1, 0); drive(0, 0, 0, 0, 1); endtask

  task automatic summary_and_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    mismatched++;
    $display("FAIL %s watchdog actual=running expected=done", cur_req);
    summary_and_end();
  end

  initial begin
    rst_n = 1'b0; reg_we = 0; reg_sel = 0; reg_wdata = 0; xfer_size = 0;
    dual_addr = 1'b1; single_to_dev = 0; rd_cyc = 0; wr_cyc = 0;
    @(negedge clk); @(negedge clk);
    cur_req = "R1"; compare_all();
    rst_n = 1'b1;
    drive(0, 0, 0, 0, 0);

    cur_req = "R11"; wr_addr(32'h0000_1000);

    cur_req = "R2"; wr_ctrl(32'h1);
    for (int s = 0; s < 4; s++) begin
      xfer_size = 2'(s);
      one_unit(); one_unit();
    end
    xfer_size = 2'd2; wr_addr(32'hFFFF_FFFE); one_unit();   // R2 wrap
    xfer_size = 2'd3; wr_addr(32'hFFFF_FFF8); one_unit();

    cur_req = "R3"; wr_ctrl(32'h2); wr_addr(32'h0000_0100);
    for (int s = 0; s < 3; s++) begin
      xfer_size = 2'(s);
      one_unit(); one_unit();
    end
    wr_addr(32'h0000_0002); one_unit();

    cur_req = "R4"; wr_ctrl(32'h0);
    for (int s = 0; s < 3; s++) begin xfer_size = 2'(s); one_unit(); end

    cur_req = "R5"; xfer_size = 2'd1; wr_ctrl(32'h3); one_unit(); one_unit();
    xfer_size = 2'd3; wr_ctrl(32'h0); one_unit();
    wr_ctrl(32'h2); one_unit();
    wr_ctrl(32'h1); one_unit();

    cur_req = "R6"; xfer_size = 2'd0; wr_ctrl(32'h01); one_unit();
    wr_ctrl(32'h11); one_unit();

    cur_req = "R8"; wr_ctrl(32'h21); one_unit();
    wr_ctrl(32'h31); one_unit(); drive(0, 0, 0, 0, 0);

    cur_req = "R7"; dual_addr = 1'b0; single_to_dev = 1'b1;
    wr_ctrl(32'h13); one_unit(); one_unit();
    wr_ctrl(32'h02); xfer_size = 2'd3; one_unit();
    single_to_dev = 1'b0; wr_ctrl(32'h21); xfer_size = 2'd1; one_unit();
    dual_addr = 1'b1;

    cur_req = "R9"; wr_ctrl(32'h31); one_unit(); wr_ctrl(32'h21); one_unit();

    cur_req = "R10"; wr_ctrl(32'hFFFF_FFFF); one_unit();
    wr_ctrl(32'hFFFF_FFCD); one_unit();

    cur_req = "R11"; xfer_size = 2'd2; wr_ctrl(32'h1);
    drive(1, 1, 32'h0000_4000, 0, 1);
    one_unit();

    summary_and_end();
  end
endmodule